// File: doc/BRIEF.md
# Register-mapped GPIO line controller

This block sits on a simple register port and owns a bank of general-purpose I/O lines, eight to sixty-four wide. Each line has an output latch, an output-enable bit and a synchronised copy of its pad input. Software can load the whole latch in one write. It can also raise or drop single lines with write-one-to-set and write-one-to-clear words, so no read-modify-write is needed and two agents cannot race. Line direction can be written either as an output mask or as an input mask. Both views always read back as exact complements.

The register port has a valid strobe, a write flag, a three-bit word address and a data word as wide as the line count. A read issued on one clock edge presents its data on `bus_rdata` after that edge, and the value holds until the next read. A parameter selects mirrored numbering. In that mode line n sits at register bit (LINES-1-n) in every register. A line count other than 8, 16, 32 or 64 is rejected when the design is elaborated.

Top module: `gpio_regblock`

## Requirements
- R1: After reset every line is an input and every latch bit is 0: `pad_oe` and `pad_out` are all zeros, the output-direction word (offset 3) reads all zeros and the input-direction word (offset 4) reads all ones.
- R2: A read of offset 0 returns the pad inputs through a two-stage synchroniser. A pad change made just after edge E reaches reads captured at edge E+3 and later, and reads captured at E+1 and E+2 return the old value. The value returned does not depend on the latch or on direction.
- R3: A write to offset 0 loads all latch bits from the write word, and `pad_out` shows the new value after that edge.
- R4: A write to offset 1 sets each latch bit whose write bit is 1 and leaves the bits written as 0 unchanged.
- R5: A write to offset 2 clears each latch bit whose write bit is 1 and leaves the bits written as 0 unchanged.
- R6: A read of offset 1 returns the output latch, for input lines as well as output lines.
- R7: A write to offset 3 makes lines with a 1 outputs (`pad_oe` bit 1) and lines with a 0 inputs. Direction changes only on writes to offset 3 or 4.
- R8: A write to offset 4 makes lines with a 1 inputs. Offset 4 always reads as the bitwise complement of offset 3.
- R9: Offset 2 and offsets 5 to 7 read as zero. Writes to offsets 5 to 7 change neither the latch nor the direction.
- R10: With REVERSE set, line n corresponds to register bit (LINES-1-n) in the data, set, clear and both direction registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | LINES | Write word |
| bus_rdata | output | LINES | Read word, registered |
| pad_in | input | LINES | Pad input levels, asynchronous |
| pad_out | output | LINES | Output latch per line |
| pad_oe | output | LINES | Output enable per line |

## Verification
The embedded properties check every cycle that set and clear words touch only the bits they name. They also check that direction holds between direction writes, that unmapped and clear-offset reads return zero, and that the input-direction view is the complement of the output-enable state. Only the bench scenarios can show the synchroniser latency in cycles, whole-word loads, latch readback on input lines, the reset values and the mirrored mapping on the pad pins. The mirrored mapping is checked with a second instance built with REVERSE set.

// File: rtl/gpio_regblock_pkg.sv
// Package: shared register offsets for the GPIO register block.
// Assumes a word-addressed port with a three-bit offset.
package gpio_regblock_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA   = 3'd0,
        OFS_SET    = 3'd1,
        OFS_CLR    = 3'd2,
        OFS_DIROUT = 3'd3,
        OFS_DIRIN  = 3'd4
    } reg_ofs_e;

    localparam logic [ADDR_W-1:0] OFS_LAST = OFS_DIRIN;
endpackage

// File: rtl/gpio_bit_order.sv
// Module: maps a word between register bit order and line order.
// Assumes the mapping is its own inverse, so one instance serves both ways.
module gpio_bit_order #(
    parameter int LINES   = 32,
    parameter bit REVERSE = 1'b0
) (
    input  logic [LINES-1:0] word_in,
    output logic [LINES-1:0] word_out
);
    // Pick a straight wire or a mirrored wire per bit.
    for (genvar i = 0; i < LINES; i++) begin : g_bit
        if (REVERSE) begin : g_mirror
            assign word_out[i] = word_in[LINES-1-i];
        end else begin : g_straight
            assign word_out[i] = word_in[i];
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchroniser for the asynchronous pad inputs.
// Assumes the inputs are quasi-static per bit. No bus-level coherence is given.
module gpio_in_sync #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);
    logic [LINES-1:0] stage1_q;
    logic [LINES-1:0] stage2_q;

    // Shift the pad levels through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_reg_decode.sv
// Module: turns a register access into write strobes and selects read data.
// All words here are in line order. The parent handles the bit mapping.
module gpio_reg_decode
    import gpio_regblock_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  sync_line,
    input  logic [LINES-1:0]  latch_line,
    input  logic [LINES-1:0]  oe_line,
    output logic              wr_data,
    output logic              wr_set,
    output logic              wr_clr,
    output logic              wr_dirout,
    output logic              wr_dirin,
    output logic              rd_en,
    output logic [LINES-1:0]  rd_line
);
    logic wr_any;

    assign wr_any    = bus_valid && bus_write;
    assign rd_en     = bus_valid && !bus_write;
    assign wr_data   = wr_any && (bus_addr == OFS_DATA);
    assign wr_set    = wr_any && (bus_addr == OFS_SET);
    assign wr_clr    = wr_any && (bus_addr == OFS_CLR);
    assign wr_dirout = wr_any && (bus_addr == OFS_DIROUT);
    assign wr_dirin  = wr_any && (bus_addr == OFS_DIRIN);

    // Read mux. The clear offset and unmapped offsets return zero.
    always_comb begin
        unique case (bus_addr)
            OFS_DATA:   rd_line = sync_line;
            OFS_SET:    rd_line = latch_line;
            OFS_DIROUT: rd_line = oe_line;
            OFS_DIRIN:  rd_line = ~oe_line;
            default:    rd_line = '0;
        endcase
    end
endmodule

// File: rtl/gpio_out_bank.sv
// Module: holds the output latch and output-enable bits for every line.
// Assumes at most one strobe is active per cycle, since the strobes come from a
// single address decode.
module gpio_out_bank #(
    parameter int LINES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic             wr_dirout,
    input  logic             wr_dirin,
    input  logic [LINES-1:0] word,
    output logic [LINES-1:0] latch_q,
    output logic [LINES-1:0] oe_q
);
    // Update the output latch: whole-word load, set by mask or clear by mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr_data) begin
            latch_q <= word;
        end else if (wr_set) begin
            latch_q <= latch_q | word;
        end else if (wr_clr) begin
            latch_q <= latch_q & ~word;
        end
    end

    // Update direction from either the output view or the input view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= '0;
        end else if (wr_dirout) begin
            oe_q <= word;
        end else if (wr_dirin) begin
            oe_q <= ~word;
        end
    end

    // R4
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((latch_q & $past(word)) == $past(word)));

    // R4
    set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((latch_q & ~$past(word)) == ($past(latch_q) & ~$past(word))));

    // R5
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((latch_q & $past(word)) == '0));

    // R5
    clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((latch_q & ~$past(word)) == ($past(latch_q) & ~$past(word))));

    // R7
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_dirout || wr_dirin) |=> $stable(oe_q));
endmodule

// File: rtl/gpio_regblock.sv
// Module: top of the GPIO register block. It joins the decode, latch bank,
// synchroniser and bit-order maps, and registers the read data.
// Assumes a bus master that takes read data on the cycle after the request.
module gpio_regblock
    import gpio_regblock_pkg::*;
#(
    parameter int LINES   = 32,
    parameter bit REVERSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe
);
    // Reject any line count that is not a supported register width.
    if (!(LINES == 8 || LINES == 16 || LINES == 32 || LINES == 64)) begin : g_bad_width
        $error("gpio_regblock: LINES must be 8, 16, 32 or 64");
    end

    logic [LINES-1:0] wword_line;
    logic [LINES-1:0] sync_line;
    logic [LINES-1:0] rd_line;
    logic [LINES-1:0] rd_bus;
    logic [LINES-1:0] oe_bus;
    logic             wr_data, wr_set, wr_clr, wr_dirout, wr_dirin, rd_en;

    gpio_bit_order #(.LINES(LINES), .REVERSE(REVERSE)) u_wmap (
        .word_in (bus_wdata),
        .word_out(wword_line)
    );

    gpio_bit_order #(.LINES(LINES), .REVERSE(REVERSE)) u_rmap (
        .word_in (rd_line),
        .word_out(rd_bus)
    );

    gpio_bit_order #(.LINES(LINES), .REVERSE(REVERSE)) u_oemap (
        .word_in (pad_oe),
        .word_out(oe_bus)
    );

    gpio_in_sync #(.LINES(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(sync_line)
    );

    gpio_reg_decode #(.LINES(LINES)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .sync_line (sync_line),
        .latch_line(pad_out),
        .oe_line   (pad_oe),
        .wr_data   (wr_data),
        .wr_set    (wr_set),
        .wr_clr    (wr_clr),
        .wr_dirout (wr_dirout),
        .wr_dirin  (wr_dirin),
        .rd_en     (rd_en),
        .rd_line   (rd_line)
    );

    gpio_out_bank #(.LINES(LINES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .wr_set   (wr_set),
        .wr_clr   (wr_clr),
        .wr_dirout(wr_dirout),
        .wr_dirin (wr_dirin),
        .word     (wword_line),
        .latch_q  (pad_out),
        .oe_q     (pad_oe)
    );

    // Capture read data when a read is issued and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_bus;
        end
    end

    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr > OFS_LAST || bus_addr == OFS_CLR))
        |=> (bus_rdata == '0));

    // R8
    dirin_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == OFS_DIRIN)
        |=> (bus_rdata == ~$past(oe_bus)));

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr > OFS_LAST)
        |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/gpio_regblock_tb_top.sv
// Bench for gpio_regblock. It walks a vector table, then runs directed tests
// for reset, synchroniser latency, pad outputs and mirrored numbering.
module gpio_regblock_tb_top;
    localparam int CLK_P = 10;
    localparam int LINES = 32;
    localparam int NVEC  = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic [LINES-1:0] bus_wdata = '0;
    logic [LINES-1:0] bus_rdata;
    logic [LINES-1:0] pad_in = 32'hA5A5_0F0F;
    logic [LINES-1:0] pad_out;
    logic [LINES-1:0] pad_oe;
    logic [7:0]       rdata_r;
    logic [7:0]       pad_in_r = 8'h00;
    logic [7:0]       pad_out_r;
    logic [7:0]       pad_oe_r;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    gpio_regblock #(.LINES(LINES), .REVERSE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    gpio_regblock #(.LINES(8), .REVERSE(1'b1)) dut_rev_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata[7:0]), .bus_rdata(rdata_r),
        .pad_in(pad_in_r), .pad_out(pad_out_r), .pad_oe(pad_oe_r)
    );

    // Each vector: write offset, write word, read offset, expected read word.
    localparam logic [69:0] VEC [NVEC] = '{
        {3'd0, 32'h1234_5678, 3'd1, 32'h1234_5678},  // R3 R6
        {3'd1, 32'h0000_00FF, 3'd1, 32'h1234_56FF},  // R4
        {3'd2, 32'h1200_0000, 3'd1, 32'h0034_56FF},  // R5
        {3'd3, 32'hFFFF_0000, 3'd4, 32'h0000_FFFF},  // R7 R8
        {3'd4, 32'h0F0F_0F0F, 3'd3, 32'hF0F0_F0F0},  // R8
        {3'd5, 32'hFFFF_FFFF, 3'd1, 32'h0034_56FF},  // R9
        {3'd7, 32'hFFFF_FFFF, 3'd3, 32'hF0F0_F0F0},  // R9
        {3'd1, 32'h0000_0000, 3'd1, 32'h0034_56FF},  // R4
        {3'd2, 32'h0000_0000, 3'd1, 32'h0034_56FF},  // R5
        {3'd0, 32'hDEAD_BEEF, 3'd0, 32'hA5A5_0F0F},  // R2
        {3'd2, 32'hFFFF_FFFF, 3'd2, 32'h0000_0000},  // R9
        {3'd1, 32'h8000_0001, 3'd1, 32'h8000_0001}   // R4
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [LINES-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_read(input logic [2:0] a);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 pad_out", 64'(pad_out), 64'h0);
        check("R1 pad_oe", 64'(pad_oe), 64'h0);
        do_read(3'd3);
        check("R1 dirout", 64'(bus_rdata), 64'h0);
        do_read(3'd4);
        check("R1 dirin", 64'(bus_rdata), 64'hFFFF_FFFF);

        // Table walk: write, then read back.
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][69:67], VEC[i][66:35]);
            do_read(VEC[i][34:32]);
            check($sformatf("vector %0d (R2..R9)", i), 64'(bus_rdata), 64'(VEC[i][31:0]));
        end

        // R3 R7: pad-side view after the table
        check("R3 pad_out", 64'(pad_out), 64'h8000_0001);
        check("R7 pad_oe", 64'(pad_oe), 64'hF0F0_F0F0);

        // R6: set readback on input lines, all lines inputs
        do_write(3'd3, 32'h0);
        do_write(3'd0, 32'h0F00_00F0);
        do_read(3'd1);
        check("R6 latch on inputs", 64'(bus_rdata), 64'h0F00_00F0);

        // R2: synchroniser latency
        @(negedge clk);
        pad_in = 32'h3C3C_C3C3;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check("R2 old at E+2", 64'(bus_rdata), 64'hA5A5_0F0F);
        @(negedge clk);
        check("R2 new at E+3", 64'(bus_rdata), 64'h3C3C_C3C3);
        bus_valid = 1'b0;

        // R10: mirrored numbering on the 8-line instance
        do_write(3'd0, 32'h0000_0001);
        check("R10 data to pad", 64'(pad_out_r), 64'h80);
        do_write(3'd3, 32'h0000_0003);
        check("R10 dir to pad", 64'(pad_oe_r), 64'hC0);
        do_write(3'd1, 32'h0000_0040);
        check("R10 set to pad", 64'(pad_out_r), 64'h82);
        do_write(3'd4, 32'h0000_00FE);
        check("R10 dirin to pad", 64'(pad_oe_r), 64'h80);
        pad_in_r = 8'h01;
        repeat (3) @(negedge clk);
        do_read(3'd0);
        check("R10 pad to data", 64'(rdata_r), 64'h80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule